// File: doc/BRIEF.md
# NAND Read-Retry Register Sequencer

This block programs one read-retry level into the private tuning registers of a raw NAND flash device. Software or a higher-level controller first fills a small parameter RAM with one byte per register per retry level, then tells the block how many levels are valid. A start strobe with a level index makes the block walk the flash command/address/data bus through a complete register-update transaction. It then waits for the device to finish and checks the status byte.

The transaction has a fixed shape. A parameter-entry command (0x36) comes first. Then, for each of the eight private registers, the register offset is sent on two address cycles, once for the low column byte and once for the high one, followed by one data cycle that carries the value for that register. An apply command (0x16) ends the register part. The block then holds off until ready/busy reads high, issues a read-status command (0x70), reads one status byte and ends with a single-cycle done or fail pulse. The bus is a simple one-cycle-per-phase strobe interface. The physical timing is produced elsewhere.

Top module: `nrr_read_retry_seq`

## Requirements
- R1: After reset the block is idle: busy, done, fail and all four bus strobes are low.
- R2: An accepted start produces, as its first bus cycle, a command cycle carrying 0x36. The register part ends with a command cycle carrying 0x16 right after the last data cycle.
- R3: Each register is written as exactly three consecutive bus cycles: two address cycles that both carry the same 8-bit register offset, then one data-write cycle.
- R4: Registers are written in the fixed offset order 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R5: The data byte for register position r at level m is the parameter RAM entry at address m*8+r. That entry is written through the configuration port at the same address.
- R6: After the apply command, no further bus cycle happens until ready/busy has been sampled high. The next cycle after that is a command cycle carrying 0x70, followed by exactly one read cycle. The status command appears D+1 cycles after the apply command when ready returns high D cycles after it.
- R7: The block samples status bit 0 on the read cycle. If it is 1, fail pulses for one cycle; otherwise done pulses for one cycle. Exactly one of the two pulses ends each accepted transaction.
- R8: Busy goes high in the cycle after an accepted start and stays high until the cycle in which done or fail pulses. In that cycle busy is low.
- R9: A start while busy is ignored. The running transaction keeps the level it latched and ends with a single result pulse.
- R10: A level index at or above the programmed level count is rejected. Fail pulses in the next cycle, busy stays low and no bus strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Parameter RAM write enable |
| cfg_addr | input | 6 | Parameter RAM address (level*8 + register position) |
| cfg_wdata | input | 8 | Parameter RAM write data |
| num_levels | input | 4 | Number of valid retry levels |
| start | input | 1 | Start request, one cycle |
| level | input | 3 | Retry level to program, sampled with start |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: finished with status pass |
| fail | output | 1 | One-cycle pulse: status fail or level rejected |
| bus_cmd | output | 1 | Command cycle strobe |
| bus_addr | output | 1 | Address cycle strobe |
| bus_wr | output | 1 | Data-write cycle strobe |
| bus_rd | output | 1 | Data-read cycle strobe |
| bus_dout | output | 8 | Byte driven to the flash |
| bus_din | input | 8 | Byte returned by the flash on read cycles |
| bus_ready | input | 1 | Flash ready (high) / busy (low) |

## Verification
The assertions assume that bus_ready only needs to be high on the cycle before the status command. They also assume that start may arrive in any state, and that the level count and the RAM contents stay unchanged while a transaction runs. The stimulus keeps to these assumptions. It loads the whole RAM before the first start and changes the level count only between transactions. A device model drops ready for a chosen number of cycles after each apply command and returns a fixed status byte. Extra start pulses are issued in the middle of a transaction on purpose, to exercise the ignore rule.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

    localparam int NRR_NUM_REGS   = 8;
    localparam int NRR_REG_IDX_W  = $clog2(NRR_NUM_REGS);
    localparam int NRR_STAT_FAIL  = 0;

    localparam logic [7:0] NRR_CMD_ENTER  = 8'h36;
    localparam logic [7:0] NRR_CMD_APPLY  = 8'h16;
    localparam logic [7:0] NRR_CMD_STATUS = 8'h70;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_ENTER,
        SQ_ADDR_LO,
        SQ_ADDR_HI,
        SQ_DATA,
        SQ_APPLY,
        SQ_WAIT_RDY,
        SQ_STAT_CMD,
        SQ_STAT_RD
    } nrr_state_e;

    typedef struct packed {
        logic       cmd;
        logic       addr;
        logic       wr;
        logic       rd;
        logic [7:0] dout;
    } nrr_bus_t;

    function automatic logic [7:0] nrr_reg_offset(input logic [NRR_REG_IDX_W-1:0] pos);
        logic [7:0] off;
        case (pos)
            3'd0:    off = 8'hCC;
            3'd1:    off = 8'hBF;
            3'd2:    off = 8'hAA;
            3'd3:    off = 8'hAB;
            3'd4:    off = 8'hCD;
            3'd5:    off = 8'hAD;
            3'd6:    off = 8'hAE;
            default: off = 8'hAF;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/nrr_param_ram.sv
module nrr_param_ram #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/nrr_fsm.sv
module nrr_fsm
    import nrr_pkg::*;
#(
    parameter int MAX_LEVELS = 8,
    parameter int LVL_W      = $clog2(MAX_LEVELS),
    parameter int AW         = $clog2(MAX_LEVELS * NRR_NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W:0]   num_levels,
    input  logic             ready,
    input  logic [7:0]       din,
    input  logic [7:0]       ram_q,
    output logic [AW-1:0]    ram_raddr,
    output nrr_bus_t         bus,
    output logic             busy,
    output logic             done,
    output logic             fail
);
    localparam logic [NRR_REG_IDX_W-1:0] LAST_POS = NRR_REG_IDX_W'(NRR_NUM_REGS - 1);
    localparam logic [LVL_W:0]           LVL_CAP  = (LVL_W+1)'(MAX_LEVELS);

    nrr_state_e                 state;
    logic [NRR_REG_IDX_W-1:0]   pos;
    logic [LVL_W-1:0]           lvl_q;
    logic                       out_of_range;

    assign out_of_range = ({1'b0, level} >= num_levels) || ({1'b0, level} >= LVL_CAP);
    assign ram_raddr    = AW'(lvl_q) * AW'(NRR_NUM_REGS) + AW'(pos);
    assign busy         = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            pos   <= '0;
            lvl_q <= '0;
            done  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    if (out_of_range) begin
                        fail <= 1'b1;
                    end else begin
                        lvl_q <= level;
                        pos   <= '0;
                        state <= SQ_ENTER;
                    end
                end
                SQ_ENTER:   state <= SQ_ADDR_LO;
                SQ_ADDR_LO: state <= SQ_ADDR_HI;
                SQ_ADDR_HI: state <= SQ_DATA;
                SQ_DATA: begin
                    if (pos == LAST_POS) begin
                        state <= SQ_APPLY;
                    end else begin
                        pos   <= pos + 1'b1;
                        state <= SQ_ADDR_LO;
                    end
                end
                SQ_APPLY:    state <= SQ_WAIT_RDY;
                SQ_WAIT_RDY: if (ready) state <= SQ_STAT_CMD;
                SQ_STAT_CMD: state <= SQ_STAT_RD;
                SQ_STAT_RD: begin
                    if (din[NRR_STAT_FAIL]) fail <= 1'b1;
                    else                    done <= 1'b1;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        bus = '0;
        case (state)
            SQ_ENTER:    begin bus.cmd  = 1'b1; bus.dout = NRR_CMD_ENTER;       end
            SQ_ADDR_LO,
            SQ_ADDR_HI:  begin bus.addr = 1'b1; bus.dout = nrr_reg_offset(pos); end
            SQ_DATA:     begin bus.wr   = 1'b1; bus.dout = ram_q;               end
            SQ_APPLY:    begin bus.cmd  = 1'b1; bus.dout = NRR_CMD_APPLY;       end
            SQ_STAT_CMD: begin bus.cmd  = 1'b1; bus.dout = NRR_CMD_STATUS;      end
            SQ_STAT_RD:  bus.rd = 1'b1;
            default:     bus = '0;
        endcase
    end

    // R6: status command only after ready was seen high
    a_r6_stat_after_ready: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STAT_CMD) |-> $past(ready));

    // R7: never both result pulses, and each is a single cycle
    a_r7_one_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, fail}));
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: rejected level gives fail with no bus activity
    a_r10_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && out_of_range) |=> (fail && !busy && !(bus.cmd || bus.addr || bus.wr || bus.rd)));

    // R9: a start while busy leaves the latched level untouched
    a_r9_level_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(lvl_q));

    // R3: two address cycles carry the same offset
    a_r3_dup_offset: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_ADDR_HI) |-> (bus.dout == $past(bus.dout)));
endmodule

// File: rtl/nrr_read_retry_seq.sv
module nrr_read_retry_seq
    import nrr_pkg::*;
#(
    parameter int MAX_LEVELS = 8,
    localparam int LVL_W     = $clog2(MAX_LEVELS),
    localparam int DEPTH     = MAX_LEVELS * NRR_NUM_REGS,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic [LVL_W:0]   num_levels,
    input  logic             start,
    input  logic [LVL_W-1:0] level,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             bus_cmd,
    output logic             bus_addr,
    output logic             bus_wr,
    output logic             bus_rd,
    output logic [7:0]       bus_dout,
    input  logic [7:0]       bus_din,
    input  logic             bus_ready
);
    logic [AW-1:0] ram_raddr;
    logic [7:0]    ram_q;
    nrr_bus_t      bus;

    nrr_param_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (ram_raddr),
        .rdata (ram_q)
    );

    nrr_fsm #(.MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W), .AW(AW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .level      (level),
        .num_levels (num_levels),
        .ready      (bus_ready),
        .din        (bus_din),
        .ram_q      (ram_q),
        .ram_raddr  (ram_raddr),
        .bus        (bus),
        .busy       (busy),
        .done       (done),
        .fail       (fail)
    );

    assign bus_cmd  = bus.cmd;
    assign bus_addr = bus.addr;
    assign bus_wr   = bus.wr;
    assign bus_rd   = bus.rd;
    assign bus_dout = bus.dout;

    // R2: strobes are mutually exclusive
    a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_cmd, bus_addr, bus_wr, bus_rd}));

    // R8: bus activity only while busy
    a_r8_bus_when_busy: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd || bus_addr || bus_wr || bus_rd) |-> busy);
endmodule

// File: tb/sim_nrr_read_retry_seq.sv
module sim_nrr_read_retry_seq;
    localparam int PERIOD = 10;
    localparam int NREG   = 8;
    localparam int SEQ_LEN = 1 + 3 * NREG + 3;
    localparam int OFFS [NREG] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
    // level, status byte, ready delay, expected fail
    localparam int NVEC = 6;
    localparam int VEC [NVEC][4] = '{
        '{0, 8'h00, 1, 0},
        '{3, 8'h01, 3, 1},
        '{7, 8'hE0, 2, 0},
        '{5, 8'hC1, 6, 1},
        '{1, 8'hFE, 4, 0},
        '{6, 8'h00, 9, 0}
    };

    logic clk = 0, rst = 1;
    logic cfg_we = 0;
    logic [5:0] cfg_addr = 0;
    logic [7:0] cfg_wdata = 0;
    logic [3:0] num_levels = 4'd8;
    logic start = 0;
    logic [2:0] level = 0;
    logic busy, done, fail, bus_cmd, bus_addr, bus_wr, bus_rd;
    logic [7:0] bus_dout;
    logic [7:0] bus_din;
    logic bus_ready;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int dev_status = 0, dev_delay = 1;
    logic rdy = 1'b1;
    int rdy_cnt = 0;
    int n_log = 0;
    int log_kind [256];
    int log_byte [256];
    int log_cyc  [256];

    assign bus_din   = dev_status[7:0];
    assign bus_ready = rdy;

    nrr_read_retry_seq u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .num_levels(num_levels), .start(start), .level(level), .busy(busy), .done(done),
        .fail(fail), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_dout(bus_dout), .bus_din(bus_din), .bus_ready(bus_ready)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // bus logger and ready/busy model
    always @(negedge clk) begin
        if (bus_cmd || bus_addr || bus_wr || bus_rd) begin
            if (n_log < 256) begin
                log_kind[n_log] = bus_cmd ? 0 : bus_addr ? 1 : bus_wr ? 2 : 3;
                log_byte[n_log] = int'(bus_dout);
                log_cyc[n_log]  = cyc;
            end
            n_log = n_log + 1;
        end
        if (bus_cmd && bus_dout == 8'h16) begin
            rdy = 1'b0;
            rdy_cnt = dev_delay;
        end else if (rdy_cnt > 0) begin
            rdy_cnt = rdy_cnt - 1;
            if (rdy_cnt == 0) rdy = 1'b1;
        end
    end

    function automatic int pval(int m, int r);
        return ((m * 29 + r * 13 + 7) ^ 8'h5A) & 255;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected bus entry j for level m: kind and byte
    task automatic exp_entry(int m, int j, output int k, output int b);
        if (j == 0) begin k = 0; b = 8'h36; end
        else if (j <= 3 * NREG) begin
            int r = (j - 1) / 3;
            int p = (j - 1) % 3;
            k = (p == 2) ? 2 : 1;
            b = (p == 2) ? pval(m, r) : OFFS[r];
        end
        else if (j == 3 * NREG + 1) begin k = 0; b = 8'h16; end
        else if (j == 3 * NREG + 2) begin k = 0; b = 8'h70; end
        else begin k = 3; b = -1; end
    endtask

    // one transaction; inj > 0 sends an extra start that many cycles in
    task automatic run(int m, int st, int d, int inj,
                       output int n_done, output int n_fail_p, output int base,
                       output bit busy_ok);
        int waited;
        n_done = 0; n_fail_p = 0; busy_ok = 1;
        base = n_log;
        dev_status = st; dev_delay = d;
        @(negedge clk); level = m[2:0]; start = 1;
        @(negedge clk); start = 0;
        waited = 0;
        while (waited < 200) begin
            if (done) n_done++;
            if (fail) n_fail_p++;
            if (done || fail) begin
                if (busy) busy_ok = 0;
                break;
            end
            if (!busy) busy_ok = 0;
            @(negedge clk);
            waited++;
            if (inj > 0 && waited == inj) begin level = 3'((m + 4) % 8); start = 1; end
            else start = 0;
        end
        repeat (3) begin
            @(negedge clk);
            start = 0;
            if (done) n_done++;
            if (fail) n_fail_p++;
        end
    endtask

    task automatic check_seq(int m, int base, int d, string req);
        int k, b;
        check(n_log - base == SEQ_LEN, req, n_log - base, SEQ_LEN);
        for (int j = 0; j < SEQ_LEN; j++) begin
            exp_entry(m, j, k, b);
            if (log_kind[base + j] != k || (b >= 0 && log_byte[base + j] != b)) begin
                check(0, req, log_byte[base + j], b);
                return;
            end
        end
        check(1, req, 0, 0);
        // R6: status command D+1 cycles after apply
        check(log_cyc[base + 3*NREG + 2] - log_cyc[base + 3*NREG + 1] == d + 1, "R6 ready wait",
              log_cyc[base + 3*NREG + 2] - log_cyc[base + 3*NREG + 1], d + 1);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int nd, nf, base;
        bit bok;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check({busy, done, fail, bus_cmd, bus_addr, bus_wr, bus_rd} == 7'b0, "R1 reset idle",
              {busy, done, fail, bus_cmd, bus_addr, bus_wr, bus_rd}, 0);

        // R5: load parameter RAM
        for (int a = 0; a < 64; a++) begin
            cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = 8'(pval(a / 8, a % 8));
            @(negedge clk);
        end
        cfg_we = 0;

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            run(VEC[v][0], VEC[v][1], VEC[v][2], 0, nd, nf, base, bok);
            check_seq(VEC[v][0], base, VEC[v][2], "R2/R3/R4/R5 sequence");
            check(nf == VEC[v][3] && nd == 1 - VEC[v][3], "R7 result", nf * 16 + nd,
                  VEC[v][3] * 16 + (1 - VEC[v][3]));
            check(bok, "R8 busy window", bok, 1);
        end

        // R9: start while busy ignored
        run(2, 8'h00, 2, 6, nd, nf, base, bok);
        check_seq(2, base, 2, "R9 latched level kept");
        check(nd == 1 && nf == 0, "R9 single result", nd * 16 + nf, 16);

        // R10: level at count rejected, boundary accepted
        num_levels = 4'd5;
        run(5, 8'h00, 1, 0, nd, nf, base, bok);
        check(n_log == base, "R10 no bus activity", n_log - base, 0);
        check(nf == 1 && nd == 0, "R10 fail pulse", nf * 16 + nd, 16);
        check(bok, "R10 busy stays low", bok, 1);
        run(4, 8'h00, 1, 0, nd, nf, base, bok);
        check_seq(4, base, 1, "R10 boundary accepted");
        check(nd == 1 && nf == 0, "R10 boundary done", nd * 16 + nf, 16);
        num_levels = 4'd0;
        run(0, 8'h00, 1, 0, nd, nf, base, bok);
        check(n_log == base && nf == 1, "R10 zero levels", nf, 1);
        num_levels = 4'd8;

        // R1: reset mid-transaction returns to idle
        @(negedge clk); level = 3'd1; start = 1;
        @(negedge clk); start = 0;
        repeat (5) @(negedge clk);
        rst = 1;
        @(negedge clk); rst = 0;
        check({busy, bus_cmd, bus_addr, bus_wr, bus_rd} == 5'b0, "R1 reset mid-run",
              {busy, bus_cmd, bus_addr, bus_wr, bus_rd}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule